// File: doc/BRIEF.md
# Exception Vector Priority Controller

This block sits next to a CPU core and answers its exception vector fetches. It watches three reset request lines, an unimplemented-opcode trap, a software interrupt, and two banks of peripheral interrupt lines. The first bank is gated by the CPU X mask bit and the second by the CPU I mask bit. Each peripheral line also has its own local enable. When the CPU pulses the vector request strobe, the block ranks every request that qualifies in that cycle. It returns the 16-bit address of the winner on the next clock, together with a one-cycle valid flag.

Arbitration is deliberately late. The choice is made from the request lines as they stand in the strobe cycle, not from whatever caused the CPU to start exception processing. A newer, higher-ranked request therefore overrides an older one. A request that has dropped away by the strobe cycle leaves the spurious vector. Trap, software interrupt, spurious and peripheral vectors share a programmable upper byte. Reset vectors sit at fixed addresses at the top of the map.

Top module: `evp_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `vec_valid` is 0 and `vec_addr` is 16'h0000.
- R2: A strobe on `vec_req` in cycle n gives `vec_valid`=1 and the chosen address in cycle n+1. A cycle without a strobe gives `vec_valid`=0 on the next cycle, and `vec_addr` keeps its last value.
- R3: Reset lines win over everything and ignore the I and X bits. `rst_req[0]` gives 16'hFFFE, else `rst_req[1]` gives 16'hFFFC, else `rst_req[2]` gives 16'hFFFA.
- R4: With no reset, the trap gives {base,8'hF8} and beats the software interrupt, which gives {base,8'hF6}. Neither is affected by the I or X bit.
- R5: X-maskable line k, with its enable set and `xbit`=0, gives {base, 8'hF4-2k}. A lower k wins. The `ibit` has no effect on these lines.
- R6: I-maskable line j gives {base, 8'hF4-2·NX-2j}, and a lower j wins. It is granted only when its enable is set, `ibit`=0, and there is no trap, no software interrupt and no qualified X-maskable request.
- R7: If nothing qualifies, including lines that are requested but disabled or masked, the output is the spurious vector {base,8'h80}.
- R8: Only the request inputs present in the strobe cycle count. A request withdrawn before the strobe leaves no trace. A higher request arriving just before the strobe wins.
- R9: For every non-reset vector the upper byte equals `vbase_hi` as sampled in the strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_req | input | 3 | Reset requests; bit 0 is highest |
| trap_req | input | 1 | Unimplemented-opcode trap request |
| swi_req | input | 1 | Software interrupt request |
| xirq_req | input | NX | X-maskable peripheral requests |
| xirq_en | input | NX | Local enables for X-maskable lines |
| iirq_req | input | NI | I-maskable peripheral requests |
| iirq_en | input | NI | Local enables for I-maskable lines |
| ibit | input | 1 | CPU I mask bit (1 = masked) |
| xbit | input | 1 | CPU X mask bit (1 = masked) |
| vbase_hi | input | 8 | Upper byte of the vector base |
| vec_req | input | 1 | CPU vector fetch strobe |
| vec_addr | output | 16 | Registered vector address |
| vec_valid | output | 1 | One-cycle flag for a fresh vector |

## Verification
The properties assume that `vec_req` is held low while `rst` is high, so that no strobe is pending on the first cycle after reset. They also assume that all inputs are stable across each rising edge. The bench changes every input on the falling edge and strobes only after reset has been released. The defaults are NX=2 and NI=8, so every peripheral offset stays strictly between the spurious and software-interrupt offsets. The properties rely on that spacing.

// File: rtl/evp_pkg.sv
package evp_pkg;

    typedef enum logic [2:0] {
        SRC_RST_TOP,
        SRC_RST_CLK,
        SRC_RST_WDG,
        SRC_TRAP,
        SRC_SWI,
        SRC_XLINE,
        SRC_ILINE,
        SRC_SPUR
    } src_e;

    typedef struct packed {
        logic       hit;
        logic [7:0] off;
    } pick_t;

    localparam logic [15:0] VEC_RST_TOP = 16'hFFFE;
    localparam logic [15:0] VEC_RST_CLK = 16'hFFFC;
    localparam logic [15:0] VEC_RST_WDG = 16'hFFFA;
    localparam logic [7:0]  OFF_TRAP    = 8'hF8;
    localparam logic [7:0]  OFF_SWI     = 8'hF6;
    localparam logic [7:0]  OFF_SPUR    = 8'h80;
    localparam logic [7:0]  OFF_TOP     = 8'hF4;

    // Peripheral slot s sits two bytes below slot s-1.
    function automatic logic [7:0] slot_off(int unsigned slot);
        return OFF_TOP - 8'(2 * slot);
    endfunction

    function automatic logic [15:0] vec_of(src_e src, logic [7:0] base, logic [7:0] off);
        case (src)
            SRC_RST_TOP: return VEC_RST_TOP;
            SRC_RST_CLK: return VEC_RST_CLK;
            SRC_RST_WDG: return VEC_RST_WDG;
            SRC_TRAP:    return {base, OFF_TRAP};
            SRC_SWI:     return {base, OFF_SWI};
            SRC_XLINE,
            SRC_ILINE:   return {base, off};
            default:     return {base, OFF_SPUR};
        endcase
    endfunction

endpackage

// File: rtl/evp_line_arb.sv
module evp_line_arb
    import evp_pkg::*;
#(
    parameter int unsigned N         = 4,
    parameter int unsigned BASE_SLOT = 0
) (
    input  logic [N-1:0] req,
    input  logic [N-1:0] en,
    input  logic         block,
    output pick_t        pick
);
    logic [N-1:0] live;
    assign live = req & en & {N{~block}};

    // Lowest index carries the highest offset, so it is taken last to win.
    always_comb begin
        pick = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (live[i]) begin
                pick.hit = 1'b1;
                pick.off = slot_off(BASE_SLOT + i);
            end
        end
    end
endmodule

// File: rtl/evp_resolve.sv
module evp_resolve
    import evp_pkg::*;
(
    input  logic [2:0]  rst_req,
    input  logic        trap_req,
    input  logic        swi_req,
    input  pick_t       xpick,
    input  pick_t       ipick,
    input  logic [7:0]  vbase_hi,
    output logic [15:0] addr
);
    src_e       src;
    logic [7:0] off;

    always_comb begin
        off = 8'h00;
        if (rst_req[0])      src = SRC_RST_TOP;
        else if (rst_req[1]) src = SRC_RST_CLK;
        else if (rst_req[2]) src = SRC_RST_WDG;
        else if (trap_req)   src = SRC_TRAP;
        else if (swi_req)    src = SRC_SWI;
        else if (xpick.hit) begin
            src = SRC_XLINE;
            off = xpick.off;
        end else if (ipick.hit) begin
            src = SRC_ILINE;
            off = ipick.off;
        end else             src = SRC_SPUR;
        addr = vec_of(src, vbase_hi, off);
    end
endmodule

// File: rtl/evp_ctrl.sv
module evp_ctrl
    import evp_pkg::*;
#(
    parameter int unsigned NX = 2,
    parameter int unsigned NI = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    rst_req,
    input  logic          trap_req,
    input  logic          swi_req,
    input  logic [NX-1:0] xirq_req,
    input  logic [NX-1:0] xirq_en,
    input  logic [NI-1:0] iirq_req,
    input  logic [NI-1:0] iirq_en,
    input  logic          ibit,
    input  logic          xbit,
    input  logic [7:0]    vbase_hi,
    input  logic          vec_req,
    output logic [15:0]   vec_addr,
    output logic          vec_valid
);
    // NX+NI must not exceed 58 so every slot lands above the spurious offset.
    localparam int unsigned ISLOT0 = NX;

    pick_t       xpick, ipick;
    logic        iblock;
    logic [15:0] next_addr;

    evp_line_arb #(.N(NX), .BASE_SLOT(0)) u_xarb (
        .req(xirq_req), .en(xirq_en), .block(xbit), .pick(xpick)
    );

    assign iblock = ibit | trap_req | swi_req | xpick.hit;

    evp_line_arb #(.N(NI), .BASE_SLOT(ISLOT0)) u_iarb (
        .req(iirq_req), .en(iirq_en), .block(iblock), .pick(ipick)
    );

    evp_resolve u_res (
        .rst_req(rst_req), .trap_req(trap_req), .swi_req(swi_req),
        .xpick(xpick), .ipick(ipick), .vbase_hi(vbase_hi), .addr(next_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_addr  <= '0;
            vec_valid <= 1'b0;
        end else begin
            vec_valid <= vec_req;
            if (vec_req) vec_addr <= next_addr;
        end
    end
endmodule

// File: rtl/evp_ctrl_chk.sv
module evp_ctrl_chk #(
    parameter int unsigned NX = 2,
    parameter int unsigned NI = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [2:0]    rst_req,
    input logic          trap_req,
    input logic          swi_req,
    input logic [NX-1:0] xirq_req,
    input logic [NI-1:0] iirq_req,
    input logic [7:0]    vbase_hi,
    input logic          vec_req,
    input logic [15:0]   vec_addr,
    input logic          vec_valid
);
    p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
        vec_req |=> vec_valid);
    p_valid_drops_r2: assert property (@(posedge clk) disable iff (rst)
        !vec_req |=> !vec_valid);
    p_addr_holds_r2: assert property (@(posedge clk) disable iff (rst)
        !vec_req |=> $stable(vec_addr));
    p_top_reset_r3: assert property (@(posedge clk) disable iff (rst)
        (vec_req && rst_req[0]) |=> vec_addr == 16'hFFFE);
    p_trap_r4: assert property (@(posedge clk) disable iff (rst)
        (vec_req && rst_req == 3'b000 && trap_req) |=> vec_addr == {$past(vbase_hi), 8'hF8});
    p_spurious_r7: assert property (@(posedge clk) disable iff (rst)
        (vec_req && rst_req == 3'b000 && !trap_req && !swi_req && xirq_req == '0 && iirq_req == '0)
        |=> vec_addr == {$past(vbase_hi), 8'h80});
    p_base_byte_r9: assert property (@(posedge clk) disable iff (rst)
        (vec_req && rst_req == 3'b000) |=> vec_addr[15:8] == $past(vbase_hi));
    p_even_addr_r5: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> !vec_addr[0]);
endmodule

bind evp_ctrl evp_ctrl_chk #(.NX(NX), .NI(NI)) u_chk (
    .clk(clk), .rst(rst), .rst_req(rst_req), .trap_req(trap_req),
    .swi_req(swi_req), .xirq_req(xirq_req), .iirq_req(iirq_req),
    .vbase_hi(vbase_hi), .vec_req(vec_req), .vec_addr(vec_addr),
    .vec_valid(vec_valid)
);

// File: tb/evp_ctrl_tb.sv
module evp_ctrl_tb;
    localparam int NX = 2;
    localparam int NI = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [2:0]    rst_req;
    logic          trap_req, swi_req;
    logic [NX-1:0] xirq_req, xirq_en;
    logic [NI-1:0] iirq_req, iirq_en;
    logic          ibit, xbit;
    logic [7:0]    vbase_hi;
    logic          vec_req;
    logic [15:0]   vec_addr;
    logic          vec_valid;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    evp_ctrl #(.NX(NX), .NI(NI)) u_dut (
        .clk(clk), .rst(rst), .rst_req(rst_req), .trap_req(trap_req),
        .swi_req(swi_req), .xirq_req(xirq_req), .xirq_en(xirq_en),
        .iirq_req(iirq_req), .iirq_en(iirq_en), .ibit(ibit), .xbit(xbit),
        .vbase_hi(vbase_hi), .vec_req(vec_req), .vec_addr(vec_addr),
        .vec_valid(vec_valid)
    );

    typedef struct packed {
        logic [2:0]  rq;
        logic        tr;
        logic        sw;
        logic [1:0]  xr;
        logic [1:0]  xe;
        logic [7:0]  ir;
        logic [7:0]  ie;
        logic        ib;
        logic        xb;
        logic [7:0]  base;
        logic [15:0] exp;
        logic [3:0]  tag;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{3'b001, 1'b1, 1'b1, 2'b11, 2'b11, 8'hFF, 8'hFF, 1'b0, 1'b0, 8'h40, 16'hFFFE, 4'd3},
        '{3'b110, 1'b1, 1'b0, 2'b00, 2'b00, 8'h00, 8'h00, 1'b0, 1'b0, 8'h40, 16'hFFFC, 4'd3},
        '{3'b100, 1'b0, 1'b1, 2'b00, 2'b00, 8'h00, 8'h00, 1'b1, 1'b1, 8'h40, 16'hFFFA, 4'd3},
        '{3'b000, 1'b1, 1'b1, 2'b11, 2'b11, 8'h00, 8'h00, 1'b1, 1'b1, 8'hA5, 16'hA5F8, 4'd4},
        '{3'b000, 1'b0, 1'b1, 2'b00, 2'b00, 8'h00, 8'h00, 1'b1, 1'b1, 8'h12, 16'h12F6, 4'd4},
        '{3'b000, 1'b0, 1'b0, 2'b11, 2'b11, 8'hFF, 8'hFF, 1'b0, 1'b0, 8'h30, 16'h30F4, 4'd5},
        '{3'b000, 1'b0, 1'b0, 2'b10, 2'b11, 8'h01, 8'h01, 1'b1, 1'b0, 8'h30, 16'h30F2, 4'd5},
        '{3'b000, 1'b0, 1'b0, 2'b11, 2'b11, 8'h08, 8'hFF, 1'b0, 1'b1, 8'h55, 16'h55EA, 4'd6},
        '{3'b000, 1'b0, 1'b0, 2'b00, 2'b00, 8'h24, 8'hFF, 1'b0, 1'b0, 8'h55, 16'h55EC, 4'd6},
        '{3'b000, 1'b0, 1'b1, 2'b00, 2'b00, 8'hFF, 8'hFF, 1'b0, 1'b0, 8'h55, 16'h55F6, 4'd6},
        '{3'b000, 1'b0, 1'b0, 2'b00, 2'b00, 8'hFF, 8'hFF, 1'b1, 1'b0, 8'h77, 16'h7780, 4'd7},
        '{3'b000, 1'b0, 1'b0, 2'b11, 2'b00, 8'hFF, 8'h00, 1'b0, 1'b0, 8'h77, 16'h7780, 4'd7},
        '{3'b000, 1'b0, 1'b0, 2'b11, 2'b11, 8'h00, 8'h00, 1'b0, 1'b1, 8'h9C, 16'h9C80, 4'd7},
        '{3'b000, 1'b0, 1'b0, 2'b00, 2'b00, 8'h00, 8'h00, 1'b0, 1'b0, 8'hFF, 16'hFF80, 4'd9}
    };

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        rst_req = '0; trap_req = 0; swi_req = 0; xirq_req = '0; xirq_en = '0;
        iirq_req = '0; iirq_en = '0; ibit = 0; xbit = 0; vbase_hi = 8'h00; vec_req = 0;
    endtask

    task automatic load(input vec_t v);
        rst_req = v.rq; trap_req = v.tr; swi_req = v.sw; xirq_req = v.xr; xirq_en = v.xe;
        iirq_req = v.ir; iirq_en = v.ie; ibit = v.ib; xbit = v.xb; vbase_hi = v.base;
    endtask

    // Strobe on one falling edge, sample on the next one.
    task automatic strobe_and_check(input string req, input logic [15:0] exp);
        vec_req = 1'b1;
        @(negedge clk);
        vec_req = 1'b0;
        check(vec_valid === 1'b1, {req, " valid"}, {15'd0, vec_valid}, 16'd1);
        check(vec_addr === exp, req, vec_addr, exp);
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state while reset is asserted
        check(vec_valid === 1'b0 && vec_addr === 16'h0000, "R1", vec_addr, 16'h0000);
        rst = 1'b0;
        @(negedge clk);
        check(vec_valid === 1'b0 && vec_addr === 16'h0000, "R1", vec_addr, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            load(TBL[i]);
            strobe_and_check($sformatf("R%0d row %0d", TBL[i].tag, i), TBL[i].exp);
        end

        // R2: no strobe leaves valid low and the address held
        idle_inputs();
        load(TBL[3]);
        strobe_and_check("R2 prime", 16'hA5F8);
        rst_req = 3'b001;
        @(negedge clk);
        check(vec_valid === 1'b0, "R2 valid pulse", {15'd0, vec_valid}, 16'd0);
        check(vec_addr === 16'hA5F8, "R2 hold", vec_addr, 16'hA5F8);

        // R8: request withdrawn before the strobe becomes spurious
        idle_inputs();
        vbase_hi = 8'h66;
        xirq_req = 2'b01; xirq_en = 2'b01;
        @(negedge clk);
        xirq_req = 2'b00;
        strobe_and_check("R8 vanished", 16'h6680);

        // R8: higher request arriving just before the strobe wins
        idle_inputs();
        vbase_hi = 8'h66;
        iirq_req = 8'h80; iirq_en = 8'h80;
        @(negedge clk);
        xirq_req = 2'b10; xirq_en = 2'b10;
        strobe_and_check("R8 override", 16'h66F2);

        // R6: lowest-ranked I line, lowest slot offset
        idle_inputs();
        vbase_hi = 8'h01;
        iirq_req = 8'h80; iirq_en = 8'h80;
        strobe_and_check("R6 last line", 16'h01E2);

        // R2: back-to-back strobes each produce a vector
        idle_inputs();
        vbase_hi = 8'h02;
        swi_req = 1'b1;
        vec_req = 1'b1;
        @(negedge clk);
        check(vec_valid === 1'b1 && vec_addr === 16'h02F6, "R2 b2b first", vec_addr, 16'h02F6);
        swi_req = 1'b0; trap_req = 1'b1;
        @(negedge clk);
        vec_req = 1'b0;
        check(vec_valid === 1'b1 && vec_addr === 16'h02F8, "R2 b2b second", vec_addr, 16'h02F8);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule